// File: doc/BRIEF.md
# Segment Latch Display Port

This block is a write-only peripheral that sits on a CPU bus with a 16-bit address and 8-bit data. It holds six banks of eight single-bit latches. Each bank drives one seven-segment digit, and each latch in a bank drives one segment or the decimal point. Software lights a segment by writing to that segment's own address. Only bit 0 of the written byte is kept.

The address is only partly decoded. The high byte picks the device page. A three-bit field picks the digit, and another three-bit field picks the latch inside that digit. Two address bits are never looked at, so each latch answers at four mirrored addresses. A separate device-select output reports a page match, so other logic can use it.

Top module: `segdisp_top`

## Requirements
- R1: When rst_n is low at a rising clock edge, all 48 latches clear to 0 (off).
- R2: A write changes state only when bus_addr[15:8] equals 0xC1. dev_sel is high exactly when bus_addr[15:8] equals 0xC1, whatever bus_wr is.
- R3: bus_addr[6:4] picks the digit: 6 drives seg_h, 5 drives seg_i, 4 drives seg_n, 3 drives seg_z, 2 drives seg_v, 1 drives seg_c. A write with code 0 or 7 changes no latch.
- R4: bus_addr[2:0] = n picks the latch that drives bit n of the digit's output. The vector is {DP, a, b, c, d, e, f, g} from bit 7 down to bit 0, so 6 is segment a, 0 is g and 7 is the decimal point.
- R5: bus_addr[7] and bus_addr[3] have no effect. 0xC166, 0xC16E, 0xC1E6 and 0xC1EE all address segment a of digit H.
- R6: Only bus_wdata[0] is stored: 1 is on and 0 is off. Bits 7:1 are ignored.
- R7: A latch keeps its value until a write addresses that same latch. While bus_wr is low, no output changes.
- R8: A write is a one-cycle strobe on bus_wr. It shows on the outputs after the next rising edge, and at most one latch changes per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data; only bit 0 is used |
| bus_wr | input | 1 | Single-cycle write strobe |
| dev_sel | output | 1 | High when the address lies in the device page |
| seg_h | output | 8 | Digit H segments {DP,a,b,c,d,e,f,g} |
| seg_i | output | 8 | Digit I segments |
| seg_n | output | 8 | Digit N segments |
| seg_z | output | 8 | Digit Z segments |
| seg_v | output | 8 | Digit V segments |
| seg_c | output | 8 | Digit C segments |

## Verification
Two functions can meet in one cycle: storing into a latch, and the synchronous reset or the hold of all the other latches. The bench provokes this by writing to latches that are already lit. It also holds bus_wr low while the address and data point at a latch. It then raises reset over a display full of lit segments. After every edge the scoreboard compares all 48 outputs against a model built from the requirements. A single latch that is wrongly dropped or added shows up as a mismatch.

// File: rtl/segdisp_pkg.sv
// Package: shared constants for the segment latch display.
// Assumes a 16-bit address bus and one bit of storage per segment.
package segdisp_pkg;
    localparam int          ADDR_W     = 16;
    localparam int          DATA_W     = 8;
    localparam int          NUM_DIGITS = 6;
    localparam int          NUM_SEGS   = 8;
    localparam int          SEL_W      = $clog2(NUM_SEGS);
    localparam int          CODE_W     = 3;
    localparam logic [7:0]  PAGE       = 8'hC1;
    // Field positions inside the address
    localparam int          PAGE_LSB   = 8;
    localparam int          CODE_LSB   = 4;
    localparam int          SEG_LSB    = 0;

    // Digit codes as seen on the address digit field
    typedef enum logic [CODE_W-1:0] {
        DIG_NONE0 = 3'd0,
        DIG_C     = 3'd1,
        DIG_V     = 3'd2,
        DIG_Z     = 3'd3,
        DIG_N     = 3'd4,
        DIG_I     = 3'd5,
        DIG_H     = 3'd6,
        DIG_NONE7 = 3'd7
    } digit_code_e;
endpackage

// File: rtl/segdisp_decode.sv
// Module: segdisp_decode
// Partial address decoder. Makes the page match, a one-hot digit enable
// (index k = digit code k+1) and a one-hot latch select. Bits that are not
// listed here are never looked at, which gives the mirrored addresses.
module segdisp_decode
    import segdisp_pkg::*;
#(
    parameter int N_DIG = NUM_DIGITS,
    parameter int N_SEG = NUM_SEGS
) (
    input  logic [7:0]        page_bits,
    input  logic [CODE_W-1:0] code_bits,
    input  logic [SEL_W-1:0]  seg_bits,
    output logic              page_hit,
    output logic [N_DIG-1:0]  dig_onehot,
    output logic [N_SEG-1:0]  seg_onehot
);
    // Page match on the high address byte
    always_comb page_hit = (page_bits == PAGE);

    // One digit enable per valid code; codes 0 and 7 match none
    for (genvar k = 0; k < N_DIG; k++) begin : g_dig
        always_comb dig_onehot[k] = page_hit && (code_bits == CODE_W'(k + 1));
    end

    // One latch select per segment index
    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        always_comb seg_onehot[s] = (seg_bits == SEL_W'(s));
    end
endmodule

// File: rtl/segdisp_bank.sv
// Module: segdisp_bank
// One digit: N_SEG single-bit latches. When bank_we is high, the latch
// picked by the one-hot sel_onehot takes d_in at the rising edge.
// Assumes sel_onehot has at most one bit set.
module segdisp_bank #(
    parameter int N_SEG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_we,
    input  logic [N_SEG-1:0] sel_onehot,
    input  logic             d_in,
    output logic [N_SEG-1:0] q
);
    for (genvar s = 0; s < N_SEG; s++) begin : g_bit
        // Store one segment bit; clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[s] <= 1'b0;
            else if (bank_we && sel_onehot[s])
                q[s] <= d_in;
        end
    end
endmodule

// File: rtl/segdisp_top.sv
// Module: segdisp_top
// Write-only six-digit segment latch display. Each segment has its own
// address, and bus_wdata[0] is stored on a one-cycle bus_wr strobe.
// Assumes a synchronous bus, and a write strobe that is high for one cycle
// per access.
module segdisp_top
    import segdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic              dev_sel,
    output logic [7:0]        seg_h,
    output logic [7:0]        seg_i,
    output logic [7:0]        seg_n,
    output logic [7:0]        seg_z,
    output logic [7:0]        seg_v,
    output logic [7:0]        seg_c
);
    logic                  page_hit;
    logic [NUM_DIGITS-1:0] dig_en;
    logic [NUM_SEGS-1:0]   seg_sel;
    logic [NUM_SEGS-1:0]   bank_q [NUM_DIGITS];
    // Address bits 7 and 3 and data bits 7:1 are deliberately not decoded
    logic                  unused_bits;

    // Gather the undecoded bits in one place
    always_comb unused_bits = ^{bus_addr[7], bus_addr[3], bus_wdata[DATA_W-1:1]};

    segdisp_decode #(.N_DIG(NUM_DIGITS), .N_SEG(NUM_SEGS)) u_dec (
        .page_bits  (bus_addr[PAGE_LSB +: 8]),
        .code_bits  (bus_addr[CODE_LSB +: CODE_W]),
        .seg_bits   (bus_addr[SEG_LSB +: SEL_W]),
        .page_hit   (page_hit),
        .dig_onehot (dig_en),
        .seg_onehot (seg_sel)
    );

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_bank
        segdisp_bank #(.N_SEG(NUM_SEGS)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .bank_we    (bus_wr && dig_en[k]),
            .sel_onehot (seg_sel),
            .d_in       (bus_wdata[0]),
            .q          (bank_q[k])
        );
    end

    // Drive the device select and route the banks to named digits (bank k = code k+1)
    always_comb begin
        dev_sel = page_hit;
        seg_c   = bank_q[0];
        seg_v   = bank_q[1];
        seg_z   = bank_q[2];
        seg_n   = bank_q[3];
        seg_i   = bank_q[4];
        seg_h   = bank_q[5];
    end
endmodule

// File: rtl/segdisp_chk.sv
// Module: segdisp_chk
// Property checker for segdisp_top, attached by bind below.
module segdisp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        dev_sel,
    input logic [7:0]  seg_h,
    input logic [7:0]  seg_i,
    input logic [7:0]  seg_n,
    input logic [7:0]  seg_z,
    input logic [7:0]  seg_v,
    input logic [7:0]  seg_c
);
    logic [47:0] all_segs;
    // Flatten all digit outputs for whole-state checks
    always_comb all_segs = {seg_h, seg_i, seg_n, seg_z, seg_v, seg_c};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (all_segs == 48'd0));

    p_offpage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:8] != 8'hC1) |=> $stable(all_segs));

    p_unused_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:8] == 8'hC1 &&
         (bus_addr[6:4] == 3'd0 || bus_addr[6:4] == 3'd7)) |=> $stable(all_segs));

    // R4, R5, R6: a write to digit H sets the addressed bit to data bit 0
    p_store_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:8] == 8'hC1 && bus_addr[6:4] == 3'd6)
        |=> (seg_h[$past(bus_addr[2:0])] == $past(bus_wdata[0])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(all_segs));

    p_one_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ($countones(all_segs ^ $past(all_segs)) <= 1));
endmodule

bind segdisp_top segdisp_chk u_chk (.*);

// File: tb/segdisp_top_tb.sv
// Scoreboard bench for segdisp_top.
module segdisp_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        dev_sel;
    logic [7:0]  seg_h, seg_i, seg_n, seg_z, seg_v, seg_c;

    typedef struct {
        logic [47:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    event        ev_push;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [7:0]  model [0:7];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    segdisp_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .dev_sel(dev_sel), .seg_h(seg_h), .seg_i(seg_i),
        .seg_n(seg_n), .seg_z(seg_z), .seg_v(seg_v), .seg_c(seg_c)
    );

    function automatic logic [47:0] model_vec();
        return {model[6], model[5], model[4], model[3], model[2], model[1]};
    endfunction

    task automatic check1(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_now(input string tag);
        item_t it;
        it.exp = model_vec();
        it.tag = tag;
        sbq.push_back(it);
        ->ev_push;
    endtask

    // Driver: one write strobe, model update, expected item after the edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 check1({tag, " R2 dev_sel"}, {47'd0, dev_sel}, {47'd0, (a[15:8] == 8'hC1)});
        if (a[15:8] == 8'hC1 && a[6:4] >= 3'd1 && a[6:4] <= 3'd6)
            model[a[6:4]][a[2:0]] = d[0];
        @(posedge clk); #1;
        push_now(tag);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'd0;
        @(posedge clk); #1;
        push_now(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pop expected items and compare against the outputs
    initial begin
        forever begin
            @(ev_push);
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                check1(it.tag, {seg_h, seg_i, seg_n, seg_z, seg_v, seg_c}, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 16'd0; bus_wdata = 8'd0; bus_wr = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'd0;
        repeat (3) @(posedge clk);
        do_reset("R1 reset state");

        // R4/R5 mirrors of H segment a
        wr(16'hC166, 8'h01, "R4 H.a set");
        check1("R4 H.a bit6", {40'd0, seg_h}, {40'd0, 8'h40});
        wr(16'hC16E, 8'h00, "R5 mirror bit3 clear");
        wr(16'hC1E6, 8'h01, "R5 mirror bit7 set");
        wr(16'hC1EE, 8'h00, "R5 mirror bits7+3 clear");

        // R6 only bit 0 matters
        wr(16'hC163, 8'hFE, "R6 0xFE stores off");
        wr(16'hC163, 8'h01, "R6 0x01 stores on");
        wr(16'hC163, 8'hFF, "R6 0xFF stays on");
        wr(16'hC163, 8'h80, "R6 0x80 clears");

        // R2 off-page writes
        wr(16'hC066, 8'h01, "R2 page C0 ignored");
        wr(16'hD166, 8'h01, "R2 page D1 ignored");
        wr(16'h4166, 8'h01, "R2 page 41 ignored");

        // R3 unused digit codes
        wr(16'hC106, 8'h01, "R3 code0 ignored");
        wr(16'hC177, 8'h01, "R3 code7 ignored");
        wr(16'hC1F5, 8'h01, "R3 code7 mirror ignored");

        // R3/R4/R8 walk every digit and segment, on then off
        for (int dg = 1; dg <= 6; dg++)
            for (int sg = 0; sg < 8; sg++)
                wr({8'hC1, 1'b0, 3'(dg), 1'b0, 3'(sg)}, 8'h01, "R8 walk on");
        for (int dg = 1; dg <= 6; dg++)
            for (int sg = 0; sg < 8; sg += 2)
                wr({8'hC1, 1'b1, 3'(dg), 1'b1, 3'(sg)}, 8'h00, "R3 walk off");

        // R7 strobe low: address and data present, no write
        @(negedge clk);
        bus_addr = 16'hC161; bus_wdata = 8'h00; bus_wr = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            push_now("R7 hold with strobe low");
        end

        // R1 reset over a lit display
        do_reset("R1 reset mid-run");

        // R4 letter C on digit H: segments a,d,e,f give 0x4E
        wr(16'hC166, 8'h01, "R4 letter a");
        wr(16'hC163, 8'h01, "R4 letter d");
        wr(16'hC162, 8'h01, "R4 letter e");
        wr(16'hC161, 8'h01, "R4 letter f");
        check1("R4 letter C = 0x4E", {40'd0, seg_h}, {40'd0, 8'h4E});
        wr(16'hC117, 8'h01, "R4 C.DP bit7");
        check1("R4 C.DP", {40'd0, seg_c}, {40'd0, 8'h80});

        repeat (2) @(posedge clk);
        #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule